// File: doc/BRIEF.md
# Chainable Serial Output-Latch and Fault Readback Port

This block is the serial control and status port of a multi-channel output driver. It runs on a fast system clock. The serial clock, serial data and latch strobe arrive from an external controller, and the block synchronises them and detects their edges. While the strobe is low, command bits move into a holding shift register on each rising serial-clock edge. A rising strobe copies that register into the output-state register that drives the channels.

The rising strobe also arms a fault snapshot. The first falling serial-clock edge after it loads the per-channel fault inputs into the same shift register. Each later falling edge moves the fault bits one place toward the serial output. The serial output is always the last stage of the shift register. Several devices can therefore be chained, each serial output feeding the next device's serial input, and a chain of N devices takes CH×N clocks per transaction.

An active-low enable gates the driver outputs but does not affect the serial logic. The system clock must run at least 8 times faster than the serial clock.

Top module: `csl_chain_port`

## Requirements
- R1: While the synchronised strobe is low, each rising serial-clock edge shifts the register up by one place and takes the serial input into bit 0. After CH bits the first bit sent sits in bit CH-1. Bit i controls channel i+1.
- R2: The serial output always equals the top bit (CH-1) of the shift register. A device placed after it in a chain therefore receives the bits that overflow from it.
- R3: `drv_state` changes only on a rising strobe edge, and then takes the holding register's value. Bits shifted in while the strobe is low do not reach `drv_state`.
- R4: While the strobe is high, rising serial-clock edges do not move the shift register. With no serial-clock edge the register holds.
- R5: The first falling serial-clock edge after a strobe rise loads `flt_in` into the shift register, with bit i being the fault of channel i+1. The serial output then shows the fault bit of channel CH. Changes on `flt_in` after that load have no effect until the next strobe rise.
- R6: Every later falling serial-clock edge while the strobe is high shifts the fault data toward the serial output, taking the serial input into bit 0. In a chain, the last device therefore emits its own faults first and then those of the devices before it.
- R7: An active-high `rst` clears the shift register, the output-state register and the pending-load flag. After reset, `drv_state` and `ser_dout` are 0.
- R8: `en_n` has no effect on shifting, committing or fault readback. `drv_on` equals `drv_state` when `en_n` is 0 and is all zeros when `en_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset of all serial-port registers |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data input, asynchronous |
| ser_latch | input | 1 | Latch strobe, asynchronous |
| ser_dout | output | 1 | Serial data output, top shift-register stage |
| en_n | input | 1 | Active-low driver enable |
| flt_in | input | CH | Per-channel fault flags, bit i = channel i+1 |
| drv_state | output | CH | Committed output-state register |
| drv_on | output | CH | Enabled channel drive, drv_state gated by en_n |

## Verification
A wrong shift-register bit shows on `ser_dout` within at most CH serial clocks, and in a two-device chain it reaches the far device's output after CH more. A bad commit shows on `drv_state` about three system clocks after the strobe rises. A fault-load error shows on the serial output at the first falling serial-clock edge after the strobe. A mis-armed load flag shows up as a wrong readback bit order across the whole chain.

// File: rtl/csl_pkg.sv
package csl_pkg;
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } sig_ev_t;

   localparam int CSL_MIN_STAGES = 2;
endpackage

// File: rtl/csl_sync_edge.sv
module csl_sync_edge
   import csl_pkg::*;
#(
   parameter int STAGES   = 2,
   parameter bit WITH_EDGE = 1'b1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    async_in,
   output sig_ev_t ev
);
   initial begin
      if (STAGES < CSL_MIN_STAGES) $error("csl_sync_edge: STAGES below minimum");
   end

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[STAGES-2:0], async_in};
   end

   generate
      if (WITH_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= pipe_q[STAGES-1];
         end
         assign ev.lvl  = pipe_q[STAGES-1];
         assign ev.rise = pipe_q[STAGES-1] & ~prev_q;
         assign ev.fall = ~pipe_q[STAGES-1] & prev_q;
      end else begin : g_level
         assign ev.lvl  = pipe_q[STAGES-1];
         assign ev.rise = 1'b0;
         assign ev.fall = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/csl_shift_core.sv
module csl_shift_core #(
   parameter int CH = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sck_rise,
   input  logic          sck_fall,
   input  logic          lat_rise,
   input  logic          lat_lvl,
   input  logic          din,
   input  logic [CH-1:0] flt,
   output logic [CH-1:0] sr_q,
   output logic [CH-1:0] out_q
);
   initial begin
      if (CH < 2) $error("csl_shift_core: CH must be at least 2");
   end

   logic pend_q;
   logic do_shift;
   logic do_load;

   assign do_shift = (sck_rise & ~lat_lvl) | (sck_fall & lat_lvl & ~pend_q);
   assign do_load  = sck_fall & lat_lvl & pend_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sr_q   <= '0;
         out_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (lat_rise) begin
            out_q  <= sr_q;
            pend_q <= 1'b1;
         end else if (do_load) begin
            pend_q <= 1'b0;
         end
         if (do_load)       sr_q <= flt;
         else if (do_shift) sr_q <= {sr_q[CH-2:0], din};
      end
   end

   // R1: a rising serial clock with the strobe low shifts the serial input in
   p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
      (sck_rise && !lat_lvl) |=> (sr_q[0] == $past(din)) && (sr_q[CH-1:1] == $past(sr_q[CH-2:0])));

   // R3: the output register only moves on a strobe rise
   p_hold_out_r3: assert property (@(posedge clk) disable iff (rst)
      !lat_rise |=> $stable(out_q));

   // R3: the commit takes the holding register
   p_commit_val_r3: assert property (@(posedge clk) disable iff (rst)
      lat_rise |=> out_q == $past(sr_q));

   // R4: a rising serial clock with the strobe high leaves the register alone
   p_rise_hi_r4: assert property (@(posedge clk) disable iff (rst)
      (sck_rise && lat_lvl) |=> $stable(sr_q));

   // R4: no serial-clock edge, no change
   p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      !(sck_rise || sck_fall) |=> $stable(sr_q));

   // R5: the load after a strobe rise happens at most once
   p_load_once_r5: assert property (@(posedge clk) disable iff (rst)
      (sck_fall && lat_lvl && !lat_rise) |=> !pend_q);
endmodule

// File: rtl/csl_chain_port.sv
module csl_chain_port
   import csl_pkg::*;
#(
   parameter int CH          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ser_clk,
   input  logic          ser_din,
   input  logic          ser_latch,
   output logic          ser_dout,
   input  logic          en_n,
   input  logic [CH-1:0] flt_in,
   output logic [CH-1:0] drv_state,
   output logic [CH-1:0] drv_on
);
   sig_ev_t       ev_sck, ev_lat, ev_din;
   logic [CH-1:0] sr_w;
   logic [CH-1:0] out_w;

   csl_sync_edge #(.STAGES(SYNC_STAGES), .WITH_EDGE(1'b1)) u_sync_sck (
      .clk(clk), .rst(rst), .async_in(ser_clk), .ev(ev_sck));
   csl_sync_edge #(.STAGES(SYNC_STAGES), .WITH_EDGE(1'b1)) u_sync_lat (
      .clk(clk), .rst(rst), .async_in(ser_latch), .ev(ev_lat));
   csl_sync_edge #(.STAGES(SYNC_STAGES), .WITH_EDGE(1'b0)) u_sync_din (
      .clk(clk), .rst(rst), .async_in(ser_din), .ev(ev_din));

   csl_shift_core #(.CH(CH)) u_core (
      .clk      (clk),
      .rst      (rst),
      .sck_rise (ev_sck.rise),
      .sck_fall (ev_sck.fall),
      .lat_rise (ev_lat.rise),
      .lat_lvl  (ev_lat.lvl),
      .din      (ev_din.lvl),
      .flt      (flt_in),
      .sr_q     (sr_w),
      .out_q    (out_w)
   );

   assign ser_dout  = sr_w[CH-1];
   assign drv_state = out_w;

   generate
      for (genvar c = 0; c < CH; c++) begin : g_gate
         assign drv_on[c] = out_w[c] & ~en_n;
      end
   endgenerate

   // R7: reset state holds one cycle after rst drops
   p_reset_clear_r7: assert property (@(posedge clk)
      $fell(rst) |-> (drv_state == '0) && (ser_dout == 1'b0));

   // R8: disabled channels never drive
   p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
      en_n |-> drv_on == '0);
endmodule

// File: tb/sim_csl_chain_port.sv
module sim_csl_chain_port;
   localparam int CH = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sck = 1'b0;
   logic din = 1'b0;
   logic lat = 1'b0;
   logic en_n = 1'b0;
   logic [CH-1:0] f0 = '0;
   logic [CH-1:0] f1 = '0;
   logic dout0, dout1;
   logic [CH-1:0] st0, st1, on0, on1;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   csl_chain_port #(.CH(CH)) u0 (
      .clk(clk), .rst(rst), .ser_clk(sck), .ser_din(din), .ser_latch(lat),
      .ser_dout(dout0), .en_n(en_n), .flt_in(f0), .drv_state(st0), .drv_on(on0));

   csl_chain_port #(.CH(CH)) u1 (
      .clk(clk), .rst(rst), .ser_clk(sck), .ser_din(dout0), .ser_latch(lat),
      .ser_dout(dout1), .en_n(en_n), .flt_in(f1), .drv_state(st1), .drv_on(on1));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic gap();
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse(input logic b);
      @(negedge clk); din = b;
      gap(); sck = 1'b1;
      gap(); sck = 1'b0;
      gap();
   endtask

   task automatic send(input logic [7:0] w);
      for (int i = 7; i >= 0; i--) pulse(w[i]);
   endtask

   task automatic strobe_up();
      @(negedge clk); lat = 1'b1;
      gap();
   endtask

   task automatic strobe_down();
      @(negedge clk); lat = 1'b0;
      gap();
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk); rst = 1'b0;
      gap();
      chk("R7 state0", {4'h0, st0}, 8'h00);
      chk("R7 state1", {4'h0, st1}, 8'h00);
      chk("R7 dout", {6'h0, dout1, dout0}, 8'h00);
   endtask

   task automatic t_write(input logic [7:0] w, input logic [7:0] prev);
      send(w);
      chk("R2 dout0 top bit", {7'h0, dout0}, {7'h0, w[3]});
      chk("R2 dout1 top bit", {7'h0, dout1}, {7'h0, w[7]});
      chk("R3 no commit before strobe", {st1, st0}, prev);
      strobe_up();
      chk("R1 R3 commit chain", {st1, st0}, w);
   endtask

   task automatic t_readback(input logic [3:0] fa, input logic [3:0] fb);
      logic [7:0] v;
      v = {fb, fa};
      f0 = fa; f1 = fb;
      pulse(1'b0);
      chk("R5 load dout0", {7'h0, dout0}, {7'h0, fa[3]});
      chk("R5 load dout1", {7'h0, dout1}, {7'h0, v[7]});
      f0 = ~fa; f1 = ~fb;
      for (int k = 2; k <= 8; k++) begin
         pulse(1'b1);
         chk("R6 R4 chain readback", {7'h0, dout1}, {7'h0, v[8-k]});
      end
      chk("R6 din fills u0", {7'h0, dout0}, 8'h01);
      strobe_down();
   endtask

   task automatic t_enable(input logic [7:0] w, input logic [7:0] prev);
      @(negedge clk); en_n = 1'b1;
      send(w);
      chk("R3 R8 hold while disabled", {st1, st0}, prev);
      strobe_up();
      chk("R8 commit with en_n high", {st1, st0}, w);
      chk("R8 gated off", {on1, on0}, 8'h00);
      @(negedge clk); en_n = 1'b0;
      @(negedge clk);
      chk("R8 gated on", {on1, on0}, w);
      strobe_down();
   endtask

   task automatic t_midreset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk); rst = 1'b0;
      gap();
      chk("R7 mid reset state", {st1, st0}, 8'h00);
      chk("R7 mid reset dout", {6'h0, dout1, dout0}, 8'h00);
   endtask

   initial begin
      t_reset();
      t_write(8'h6C, 8'h00);
      t_readback(4'b1001, 4'b0110);
      t_enable(8'h93, 8'h6C);
      t_write(8'h5A, 8'h93);
      t_readback(4'b0111, 4'b1100);
      t_midreset();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule